// File: doc/BRIEF.md
# USB Link Activity LED Controller

This block drives a single status LED that shows the health of a USB device link. It takes level flags from the device-side protocol logic: enumeration under way, device address assigned and bus suspended. It also takes a one-cycle pulse for every packet that ends with an ACK handshake, in either direction. From these it forms one registered LED enable.

While the host is still enumerating the device, the LED gives brief on-flashes. Once an address is held, the LED stays lit. Each acknowledged packet blanks it for a fixed dark window, so bus traffic shows up as flicker. Suspend wins over every other input and keeps the LED dark. A link with neither an address nor enumeration activity leaves the LED off.

All durations are given in milliseconds and turned into clock cycles from a clock-frequency parameter. The same RTL therefore serves any system clock.

Top module: `link_led_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `led_on` is 0. Reset also cancels any dark window and restarts the blink phase.
- R2: With `addr_set` high, `suspend` low and no dark window active, `led_on` is 1 on the cycle after those inputs are sampled.
- R3: An `ack_pulse` sampled while `suspend` is low makes `led_on` 0 from the next cycle. It stays 0 for exactly OFF_MS milliseconds of cycles and then returns to the level the flags select.
- R4: An `ack_pulse` that arrives while a dark window is active restarts the full window from that pulse.
- R5: With `enum_busy` high and `addr_set` low, `led_on` turns 1 on the cycle after enumeration is first sampled. It stays 1 for BLINK_ON_MS of cycles, then stays 0 for the rest of a BLINK_PER_MS period, and repeats.
- R6: While `suspend` is high, `led_on` is 0 whatever the other inputs do. An `ack_pulse` sampled during suspend starts no dark window.
- R7: Suspend cancels any active dark window. On the cycle after `suspend` falls, `led_on` follows the `addr_set` and `enum_busy` flags at once.
- R8: With both `addr_set` and `enum_busy` low, `led_on` is 0.
- R9: `addr_set` takes priority over `enum_busy`: when both are high, the LED is steadily on and does not blink.
- R10: A span of N ms lasts (CLK_HZ/1000)*N clock cycles. At the 48 MHz default the dark window is 4,800,000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enum_busy | input | 1 | Enumeration in progress |
| addr_set | input | 1 | Device address has been assigned |
| suspend | input | 1 | Bus is in the suspend state |
| ack_pulse | input | 1 | One-cycle pulse per ACK-completed packet |
| led_on | output | 1 | Registered LED enable, 1 = lit |

## Verification
The block holds only two counters and one output register. A wrong internal state therefore shows up on `led_on` within one clock, or at the end of a window. A dark-window counter that loads wrong or fails to clear shows up as a low period that is too long or too short, or as a dark LED just after suspend ends. The bench counts those edges to the exact cycle. A blink phase that drifts shows at the first on/off transition of an enumeration period. A priority error shows the first cycle after the competing flags are applied.

// File: rtl/link_led_pkg.sv
package link_led_pkg;

  typedef enum logic [2:0] {
    MODE_DARK   = 3'd0,
    MODE_SUSP   = 3'd1,
    MODE_WINDOW = 3'd2,
    MODE_STEADY = 3'd3,
    MODE_FLASH  = 3'd4
  } led_mode_e;

  // Convert a duration in milliseconds to clock cycles.
  function automatic int ms_to_cycles(input int clk_hz, input int ms);
    return (clk_hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/link_off_window.sv
module link_off_window #(
  parameter int unsigned WIN_CYC = 4800000,
  localparam int unsigned CW = $clog2(WIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  output logic busy
);

  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] remain;

  // The start cycle itself is dark through the mode select, so the counter
  // holds WIN_CYC-1 further dark cycles.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      remain <= '0;
    end else if (start) begin
      remain <= RELOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/link_blink_gen.sv
module link_blink_gen #(
  parameter int unsigned PER_CYC = 24000000,
  parameter int unsigned ON_CYC  = 2400000,
  localparam int unsigned PW = (PER_CYC > 1) ? $clog2(PER_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic lit
);

  localparam logic [PW-1:0] LAST   = PW'(PER_CYC - 1);
  localparam logic [PW-1:0] ON_LIM = PW'(ON_CYC);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  generate
    if (ON_CYC >= PER_CYC) begin : g_always
      assign lit = 1'b1;
    end else begin : g_split
      assign lit = (phase < ON_LIM);
    end
  endgenerate

endmodule

// File: rtl/link_mode_sel.sv
module link_mode_sel
  import link_led_pkg::*;
(
  input  logic      suspend,
  input  logic      ack_pulse,
  input  logic      win_busy,
  input  logic      addr_set,
  input  logic      enum_busy,
  output led_mode_e mode
);

  // Fixed priority: suspend, dark window, address, enumeration, idle.
  always_comb begin
    if (suspend) begin
      mode = MODE_SUSP;
    end else if (ack_pulse || win_busy) begin
      mode = MODE_WINDOW;
    end else if (addr_set) begin
      mode = MODE_STEADY;
    end else if (enum_busy) begin
      mode = MODE_FLASH;
    end else begin
      mode = MODE_DARK;
    end
  end

endmodule

// File: rtl/link_led_top.sv
module link_led_top
  import link_led_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 48000000,
  parameter int unsigned OFF_MS       = 100,
  parameter int unsigned BLINK_ON_MS  = 50,
  parameter int unsigned BLINK_PER_MS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic enum_busy,
  input  logic addr_set,
  input  logic suspend,
  input  logic ack_pulse,
  output logic led_on
);

  localparam int unsigned OFF_CYC   = ms_to_cycles(CLK_HZ, OFF_MS);
  localparam int unsigned ON_CYC    = ms_to_cycles(CLK_HZ, BLINK_ON_MS);
  localparam int unsigned PER_CYC   = ms_to_cycles(CLK_HZ, BLINK_PER_MS);
  localparam int unsigned OFF_SAFE  = (OFF_CYC < 1) ? 1 : OFF_CYC;
  localparam int unsigned PER_SAFE  = (PER_CYC < 2) ? 2 : PER_CYC;

  logic      win_busy;
  logic      flash_lit;
  logic      flash_run;
  led_mode_e mode;
  logic      led_nxt;

  assign flash_run = enum_busy && !addr_set && !suspend;

  link_off_window #(.WIN_CYC(OFF_SAFE)) u_win (
    .clk   (clk),
    .rst   (rst),
    .start (ack_pulse && !suspend),
    .clear (suspend),
    .busy  (win_busy)
  );

  link_blink_gen #(.PER_CYC(PER_SAFE), .ON_CYC(ON_CYC)) u_blink (
    .clk (clk),
    .rst (rst),
    .run (flash_run),
    .lit (flash_lit)
  );

  link_mode_sel u_sel (
    .suspend   (suspend),
    .ack_pulse (ack_pulse),
    .win_busy  (win_busy),
    .addr_set  (addr_set),
    .enum_busy (enum_busy),
    .mode      (mode)
  );

  always_comb begin
    case (mode)
      MODE_STEADY: led_nxt = 1'b1;
      MODE_FLASH:  led_nxt = flash_lit;
      default:     led_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_on <= 1'b0;
    end else begin
      led_on <= led_nxt;
    end
  end

endmodule

// File: rtl/link_led_chk.sv
module link_led_chk (
  input logic clk,
  input logic rst,
  input logic enum_busy,
  input logic addr_set,
  input logic suspend,
  input logic ack_pulse,
  input logic win_busy,
  input logic led_on
);

  // R6
  suspend_dark_chk: assert property (@(posedge clk) disable iff (rst)
    suspend |=> !led_on);

  // R3
  ack_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !suspend) |=> !led_on);

  // R2
  steady_on_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_set && !suspend && !ack_pulse && !win_busy) |=> led_on);

  // R8
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_set && !enum_busy) |=> !led_on);

  // R7
  susp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    suspend |=> !win_busy);

endmodule

bind link_led_top link_led_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .enum_busy (enum_busy),
  .addr_set  (addr_set),
  .suspend   (suspend),
  .ack_pulse (ack_pulse),
  .win_busy  (win_busy),
  .led_on    (led_on)
);

// File: tb/sim_link_led_top.sv
module sim_link_led_top;

  localparam time CLK_PER      = 10ns;
  localparam int  CLK_HZ       = 10000;
  localparam int  OFF_MS       = 100;
  localparam int  ON_MS        = 50;
  localparam int  PER_MS       = 500;
  localparam int  CPM          = CLK_HZ / 1000;
  localparam int  OFF_CYC      = CPM * OFF_MS;
  localparam int  ON_CYC       = CPM * ON_MS;
  localparam int  PER_CYC      = CPM * PER_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enum_busy = 1'b0;
  logic addr_set = 1'b0;
  logic suspend = 1'b0;
  logic ack_pulse = 1'b0;
  logic led_on;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  link_led_top #(
    .CLK_HZ(CLK_HZ), .OFF_MS(OFF_MS), .BLINK_ON_MS(ON_MS), .BLINK_PER_MS(PER_MS)
  ) u0 (
    .clk(clk), .rst(rst), .enum_busy(enum_busy), .addr_set(addr_set),
    .suspend(suspend), .ack_pulse(ack_pulse), .led_on(led_on)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    total++;
    if (led_on !== exp) begin
      bad++;
      $display("FAIL %s: led_on=%b expected=%b at %0t", req, led_on, exp, $time);
    end
  endtask

  task automatic pulse_ack();
    ack_pulse = 1'b1;
    step(1);
    ack_pulse = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; addr_set = 1'b1;
    step(3);
    check("R1 held in reset", 1'b0);
    rst = 1'b0;
    step(1);
    check("R2 on after reset release", 1'b1);
    pulse_ack();
    step(5);
    rst = 1'b1;
    step(1);
    check("R1 reset mid-window", 1'b0);
    rst = 1'b0;
    step(1);
    check("R1 window cleared by reset", 1'b1);
    addr_set = 1'b0;
    step(1);
  endtask

  task automatic t_idle();
    addr_set = 1'b0; enum_busy = 1'b0;
    step(1);
    check("R8 idle dark", 1'b0);
    step(20);
    check("R8 idle stays dark", 1'b0);
  endtask

  task automatic t_ack_window();
    addr_set = 1'b1;
    step(1);
    check("R2 steady on", 1'b1);
    pulse_ack();
    check("R3 dark after ack", 1'b0);
    step(OFF_CYC - 1);
    check("R10 dark at last window cycle", 1'b0);
    step(1);
    check("R3 R10 lit after window", 1'b1);
  endtask

  task automatic t_restart();
    addr_set = 1'b1;
    pulse_ack();
    step(OFF_CYC / 2);
    pulse_ack();
    step(OFF_CYC - 1);
    check("R4 still dark after restart", 1'b0);
    step(1);
    check("R4 lit after restarted window", 1'b1);
  endtask

  task automatic t_blink();
    addr_set = 1'b0; enum_busy = 1'b1;
    step(1);
    check("R5 first flash on", 1'b1);
    step(ON_CYC - 1);
    check("R5 last on cycle", 1'b1);
    step(1);
    check("R5 off after on-time", 1'b0);
    step(PER_CYC - ON_CYC - 1);
    check("R5 off at period end", 1'b0);
    step(1);
    check("R5 next period on", 1'b1);
    enum_busy = 1'b0;
    step(1);
    check("R8 blink stops", 1'b0);
  endtask

  task automatic t_priority();
    addr_set = 1'b1; enum_busy = 1'b1;
    step(1);
    check("R9 addr over enum", 1'b1);
    step(ON_CYC + 10);
    check("R9 no blink-off", 1'b1);
    enum_busy = 1'b0;
    step(1);
  endtask

  task automatic t_suspend();
    addr_set = 1'b1;
    step(1);
    suspend = 1'b1;
    step(1);
    check("R6 suspend dark", 1'b0);
    pulse_ack();
    step(3);
    suspend = 1'b0;
    step(1);
    check("R6 ack in suspend ignored", 1'b1);
    pulse_ack();
    step(10);
    suspend = 1'b1;
    step(5);
    check("R6 dark over window", 1'b0);
    suspend = 1'b0;
    step(1);
    check("R7 window cleared on resume", 1'b1);
    step(10);
    check("R7 stays lit after resume", 1'b1);
    addr_set = 1'b0; enum_busy = 1'b1; suspend = 1'b1;
    step(4);
    check("R6 suspend over enum", 1'b0);
    suspend = 1'b0;
    step(1);
    check("R7 flash resumes next cycle", 1'b1);
    enum_busy = 1'b0;
    step(1);
  endtask

  initial begin
    step(1);
    check("R1 reset state", 1'b0);
    t_reset();
    t_idle();
    t_ack_window();
    t_restart();
    t_blink();
    t_priority();
    t_suspend();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule